// File: doc/BRIEF.md
# Reciprocal-Multiply Binary to Decimal Converter

This block turns a 32-bit unsigned binary word into ten packed BCD digits. It contains no divider. The input is first cut into an upper and a lower half, each holding five decimal digits. The cut uses a truncated reciprocal of 100000, and a one-step correction fixes an estimate that comes out one too low. Each half is then multiplied by a rounded-up scale constant. The constant is chosen so that the half's leading decimal digit sits above a fixed binary point. The next digits are then pulled out one per pipeline stage: mask off the digit just taken, multiply the rest by five with a shift and an add, and read the next digit one bit lower. Both halves go through this at the same time.

The input side has a valid/ready handshake. Ready goes high one clock after reset is released and then stays high. The pipeline never stalls, so it accepts a new word on every cycle. Each accepted word produces exactly one result. The result appears on the output, with a one-cycle valid pulse, a fixed seven cycles later.

Top module: `b2d_recip_conv`

## Requirements
- R1: When out_valid is high, out_bcd holds the decimal value of the input accepted seven cycles earlier. Each 4-bit nibble is one BCD digit. The most significant digit is in bits 39:36 and the units digit is in bits 3:0.
- R2: A word is accepted on a rising edge where in_valid and in_ready are both high. out_valid is high after exactly the seventh rising edge counted from the accepting edge, and low after the sixth. Words accepted on consecutive cycles give results on consecutive cycles, in the same order.
- R3: While out_valid is high, every nibble of out_bcd is in the range 0 to 9.
- R4: While out_valid is high, the most significant digit is at most 4.
- R5: While rst_n is low, in_ready is low. in_ready is high from the first rising edge after reset is released, and it stays high until the next reset.
- R6: out_valid is low during reset and in every cycle that has no accepted word seven cycles earlier.
- R7: Values at the split between the halves convert correctly. For example, 99999 gives 0000099999, 100000 gives 0000100000 and 100001 gives 0000100001.
- R8: The extreme values 0 and 4294967295 convert to 0000000000 and 4294967295.
- R9: in_valid asserted while in_ready is low is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A binary word is offered on in_bin |
| in_ready | output | 1 | The converter can take a word |
| in_bin | input | 32 | Unsigned binary value |
| out_valid | output | 1 | out_bcd holds a result this cycle |
| out_bcd | output | 40 | Ten BCD digits, most significant first |

## Verification
The checker keeps its own delayed copy of every accepted word. It therefore assumes that in_bin holds a known value on each cycle where in_valid and in_ready are both high. It also assumes that the consumer takes every result in the cycle it appears, because there is no output stall. The bench meets both assumptions. It changes in_valid and in_bin only on falling clock edges, never leaves in_bin unknown while in_valid is high, and reads each result in the exact cycle that R2 predicts. The stimulus covers the half-split boundaries, the extreme values and back-to-back random words.

// File: rtl/b2d_recip_pkg.sv
package b2d_recip_pkg;

   typedef logic [3:0] bcd_digit_t;

   // Integer power of ten, used only for elaboration-time constants.
   function automatic logic [63:0] pow10(input int n);
      logic [63:0] r;
      r = 64'd1;
      for (int i = 0; i < n; i++) r = r * 64'd10;
      return r;
   endfunction

endpackage

// File: rtl/b2d_split.sv
// Splits the binary input into quotient and remainder of the half base
// using a truncated reciprocal plus a single +1 correction step.
module b2d_split
   import b2d_recip_pkg::*;
#(
   parameter int          IN_W     = 32,
   parameter int          HALF_W   = 17,
   parameter logic [63:0] BASE     = 64'd100000,
   parameter int          SPLIT_SH = 40
)(
   input  logic              clk,
   input  logic [IN_W-1:0]   x,
   output logic [HALF_W-1:0] hi_q,
   output logic [HALF_W-1:0] lo_q
);

   localparam logic [63:0]     RECIP   = (64'd1 << SPLIT_SH) / BASE;
   localparam logic [IN_W-1:0] BASE_IN = IN_W'(BASE);

   logic [63:0]       prod;
   logic [HALF_W-1:0] q_est;
   logic [IN_W-1:0]   rem_raw;
   logic [HALF_W-1:0] hi_d;
   logic [HALF_W-1:0] lo_d;

   always_comb begin
      prod    = 64'(x) * RECIP;
      q_est   = HALF_W'(prod >> SPLIT_SH);
      rem_raw = x - IN_W'(64'(q_est) * BASE);
      if (rem_raw >= BASE_IN) begin
         hi_d = q_est + HALF_W'(1);
         lo_d = HALF_W'(rem_raw - BASE_IN);
      end else begin
         hi_d = q_est;
         lo_d = HALF_W'(rem_raw);
      end
   end

   always_ff @(posedge clk) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
   end

endmodule

// File: rtl/b2d_half.sv
// Scales one half so its leading digit sits above bit FRAC_W, then peels
// one digit per stage by masking and multiplying the remainder by five.
module b2d_half
   import b2d_recip_pkg::*;
#(
   parameter int HALF_DIG      = 5,
   parameter int HALF_W        = 17,
   parameter int FRAC_W        = 32,
   parameter bit USE_SHIFT_ADD = 1'b1
)(
   input  logic                  clk,
   input  logic [HALF_W-1:0]     v,
   output logic [4*HALF_DIG-1:0] dig
);

   localparam int          ACC_W     = FRAC_W + 4;
   localparam int          DW        = 4 * HALF_DIG;
   localparam logic [63:0] HBASE     = pow10(HALF_DIG);
   localparam logic [63:0] STEP_P    = pow10(HALF_DIG - 1);
   localparam logic [63:0] SCALE_C64 = ((64'd1 << FRAC_W) + STEP_P - 64'd1) / STEP_P;
   localparam logic [ACC_W-1:0] SCALE_C = ACC_W'(SCALE_C64);

   // The rounding error of the scale constant, grown by five per step,
   // must stay below one unit of the last digit.
   if (SCALE_C64 <= HBASE) begin : g_bad_frac
      $error("b2d_half: FRAC_W too small for HALF_DIG digits");
   end
   if (ACC_W > 63) begin : g_bad_acc
      $error("b2d_half: accumulator wider than 63 bits");
   end

   logic [ACC_W-1:0] acc0_q;

   always_ff @(posedge clk) begin
      acc0_q <= ACC_W'(v) * SCALE_C;
   end

   for (genvar k = 0; k < HALF_DIG; k++) begin : g_st
      localparam int SH = FRAC_W - k;
      logic [ACC_W-1:0] acc_in;
      logic [DW-1:0]    prior;
      bcd_digit_t       d;
      logic [DW-1:0]    dig_q;

      if (k == 0) begin : g_first
         assign acc_in = acc0_q;
         assign prior  = '0;
      end else begin : g_next
         assign acc_in = g_st[k-1].g_more.acc_nxt_q;
         assign prior  = g_st[k-1].dig_q;
      end

      assign d = 4'(acc_in >> SH);

      always_ff @(posedge clk) begin
         dig_q <= prior | ({{(DW-4){1'b0}}, d} << (4 * (HALF_DIG - 1 - k)));
      end

      if (k < HALF_DIG - 1) begin : g_more
         logic [ACC_W-1:0] rem;
         logic [ACC_W-1:0] nxt;
         logic [ACC_W-1:0] acc_nxt_q;

         assign rem = acc_in & ((ACC_W'(1) << SH) - ACC_W'(1));

         if (USE_SHIFT_ADD) begin : g_sa
            assign nxt = (rem << 2) + rem;
         end else begin : g_mul
            assign nxt = rem * ACC_W'(5);
         end

         always_ff @(posedge clk) begin
            acc_nxt_q <= nxt;
         end
      end
   end

   assign dig = g_st[HALF_DIG-1].dig_q;

endmodule

// File: rtl/b2d_recip_conv.sv
module b2d_recip_conv
   import b2d_recip_pkg::*;
#(
   parameter int IN_W          = 32,
   parameter int HALF_DIG      = 5,
   parameter int FRAC_W        = 32,
   parameter int SPLIT_SH      = 40,
   parameter bit USE_SHIFT_ADD = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [IN_W-1:0]       in_bin,
   output logic                  out_valid,
   output logic [8*HALF_DIG-1:0] out_bcd
);

   localparam logic [63:0] BASE   = pow10(HALF_DIG);
   localparam int          HALF_W = $clog2(BASE);
   localparam int          LAT    = 2 + HALF_DIG;
   localparam logic [63:0] MAX_IN = (64'd1 << IN_W) - 64'd1;

   if (MAX_IN / BASE >= BASE) begin : g_bad_halves
      $error("b2d_recip_conv: two halves cannot hold IN_W bits");
   end
   if (SPLIT_SH <= IN_W) begin : g_bad_split
      $error("b2d_recip_conv: SPLIT_SH must exceed IN_W");
   end
   if (IN_W + SPLIT_SH - $clog2(BASE) + 1 > 64) begin : g_bad_prod
      $error("b2d_recip_conv: split product exceeds 64 bits");
   end

   logic                  rdy_q;
   logic [LAT-1:0]        vld_q;
   logic [HALF_W-1:0]     hi_q;
   logic [HALF_W-1:0]     lo_q;
   logic [4*HALF_DIG-1:0] hi_dig;
   logic [4*HALF_DIG-1:0] lo_dig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         vld_q <= '0;
      end else begin
         rdy_q <= 1'b1;
         vld_q <= {vld_q[LAT-2:0], in_valid & rdy_q};
      end
   end

   b2d_split #(
      .IN_W     (IN_W),
      .HALF_W   (HALF_W),
      .BASE     (BASE),
      .SPLIT_SH (SPLIT_SH)
   ) u_split (
      .clk  (clk),
      .x    (in_bin),
      .hi_q (hi_q),
      .lo_q (lo_q)
   );

   b2d_half #(
      .HALF_DIG      (HALF_DIG),
      .HALF_W        (HALF_W),
      .FRAC_W        (FRAC_W),
      .USE_SHIFT_ADD (USE_SHIFT_ADD)
   ) u_hi (
      .clk (clk),
      .v   (hi_q),
      .dig (hi_dig)
   );

   b2d_half #(
      .HALF_DIG      (HALF_DIG),
      .HALF_W        (HALF_W),
      .FRAC_W        (FRAC_W),
      .USE_SHIFT_ADD (USE_SHIFT_ADD)
   ) u_lo (
      .clk (clk),
      .v   (lo_q),
      .dig (lo_dig)
   );

   assign in_ready  = rdy_q;
   assign out_valid = vld_q[LAT-1];
   assign out_bcd   = {hi_dig, lo_dig};

endmodule

// File: rtl/b2d_recip_chk.sv
module b2d_recip_chk
   import b2d_recip_pkg::*;
#(
   parameter int IN_W     = 32,
   parameter int HALF_DIG = 5
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  in_ready,
   input logic [IN_W-1:0]       in_bin,
   input logic                  out_valid,
   input logic [8*HALF_DIG-1:0] out_bcd
);

   localparam int          LAT      = 2 + HALF_DIG;
   localparam int          ND       = 2 * HALF_DIG;
   localparam logic [63:0] MAX_IN   = (64'd1 << IN_W) - 64'd1;
   localparam logic [63:0] LEAD_MAX = MAX_IN / pow10(ND - 1);

   logic [LAT-1:0]  h_vld;
   logic [IN_W-1:0] h_val [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) h_vld <= '0;
      else        h_vld <= {h_vld[LAT-2:0], in_valid & in_ready};
   end

   always_ff @(posedge clk) begin
      h_val[0] <= in_bin;
      for (int i = 1; i < LAT; i++) h_val[i] <= h_val[i-1];
   end

   function automatic logic [63:0] dec_of(input logic [8*HALF_DIG-1:0] b);
      logic [63:0] s;
      s = 64'd0;
      for (int i = ND - 1; i >= 0; i--) s = s * 64'd10 + 64'(b[4*i +: 4]);
      return s;
   endfunction

   function automatic bit all_dec(input logic [8*HALF_DIG-1:0] b);
      for (int i = 0; i < ND; i++) if (b[4*i +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> dec_of(out_bcd) == 64'(h_val[LAT-1])); // R1

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == h_vld[LAT-1]); // R2

   AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> all_dec(out_bcd)); // R3

   AST_LEAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_bcd[8*HALF_DIG-1 -: 4] <= 4'(LEAD_MAX)); // R4

   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready); // R5

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_QUIET_IN_RESET: assert (!in_ready && !out_valid); // R6
      end
   end

endmodule

bind b2d_recip_conv b2d_recip_chk #(
   .IN_W     (IN_W),
   .HALF_DIG (HALF_DIG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_bin    (in_bin),
   .out_valid (out_valid),
   .out_bcd   (out_bcd)
);

// File: tb/sim_b2d_recip_conv.sv
`timescale 1ns/1ps
module sim_b2d_recip_conv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_bin = '0;
   logic        out_valid;
   logic [39:0] out_bcd;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   b2d_recip_conv u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_bin    (in_bin),
      .out_valid (out_valid),
      .out_bcd   (out_bcd)
   );

   function automatic logic [39:0] ref_bcd(input logic [31:0] v);
      logic [39:0] r;
      logic [31:0] t;
      r = '0;
      t = v;
      for (int i = 0; i < 10; i++) begin
         r[4*i +: 4] = 4'(t % 32'd10);
         t = t / 32'd10;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R5 R6 R9: reset behaviour, input offered during reset is dropped
   task automatic t_reset();
      rst_n    = 1'b0;
      in_valid = 1'b1;
      in_bin   = 32'd12345;
      repeat (4) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R5 ready low in reset", 64'(in_ready), 64'd0);
         chk(out_valid == 1'b0, "R6 no output in reset", 64'(out_valid), 64'd0);
      end
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R5 ready after release", 64'(in_ready), 64'd1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R9 reset-time input ignored", 64'(out_valid), 64'd0);
         chk(in_ready == 1'b1, "R5 ready holds", 64'(in_ready), 64'd1);
      end
   endtask

   // One word: checks latency edges and value
   task automatic t_single(input logic [31:0] v, input string req);
      logic [39:0] exp;
      exp = ref_bcd(v);
      @(negedge clk);
      in_valid = 1'b1;
      in_bin   = v;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(out_valid == 1'b0, "R2 not early", 64'(out_valid), 64'd0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R2 valid on time", 64'(out_valid), 64'd1);
      chk(out_bcd == exp, req, 64'(out_bcd), 64'(exp));
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 single pulse", 64'(out_valid), 64'd0);
   endtask

   task automatic t_small();
      t_single(32'd0, "R8 zero");
      t_single(32'd9, "R1 nine");
      t_single(32'd10, "R1 ten");
      t_single(32'd1234567890, "R1 mixed digits");
   endtask

   task automatic t_split_edge();
      t_single(32'd99999, "R7 below split");
      t_single(32'd100000, "R7 at split");
      t_single(32'd100001, "R7 above split");
      t_single(32'd4294899999, "R7 low half all nines");
   endtask

   task automatic t_extreme();
      t_single(32'hFFFF_FFFF, "R8 all ones");
      t_single(32'd4000000000, "R4 lead digit");
   endtask

   // R2 R1 R3: back-to-back stream with one result per cycle
   task automatic t_stream(input int n);
      logic [31:0] vals [16];
      for (int i = 0; i < n; i++) vals[i] = $urandom();
      vals[0] = 32'd999999999;
      for (int t = 0; t < n + 7; t++) begin
         @(negedge clk);
         if (t < n) begin
            in_valid = 1'b1;
            in_bin   = vals[t];
         end else begin
            in_valid = 1'b0;
         end
         if (t >= 7) begin
            logic [39:0] e;
            bit          dec_ok;
            e = ref_bcd(vals[t-7]);
            chk(out_valid == 1'b1, "R2 stream valid", 64'(out_valid), 64'd1);
            chk(out_bcd == e, "R1 stream value", 64'(out_bcd), 64'(e));
            dec_ok = 1'b1;
            for (int j = 0; j < 10; j++) if (out_bcd[4*j +: 4] > 4'd9) dec_ok = 1'b0;
            chk(dec_ok, "R3 nibbles decimal", 64'(out_bcd), 64'(e));
         end
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R6 stream drained", 64'(out_valid), 64'd0);
   endtask

   initial begin
      t_reset();
      t_small();
      t_split_edge();
      t_extreme();
      t_stream(16);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule